// File: doc/BRIEF.md
# Extended Capability List Walker

This engine traverses the chain of extended capability headers held in a 4 KB configuration space. The space sits in a dword-wide memory with one cycle of read latency that the engine accesses through a single read/write port. Each header dword packs a 16-bit capability ID, a 4-bit version and a 12-bit byte offset to the following header. The chain always begins at byte offset 0x100, and a following-offset of zero marks its last entry.

A one-cycle `start` launches one of two operations. A find walks the chain and reports the offset of the first header whose ID equals the requested one, along with the offset of the header visited just before it. An append links a new capability onto the chain. If its offset is anything other than 0x100, the engine walks to the last header, rewrites only the following-offset field of that header, and then writes the new header with a following-offset of zero. If the offset is exactly 0x100, the engine rewrites the base header and keeps the following-offset already stored there. Every operation ends with a one-cycle `done`. The `err` output is valid alongside `done` and reports a broken bound, a broken alignment rule or a runaway chain. An operation that ends in error writes nothing to the memory.

Top module: `ecap_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are all 0.
- R2: A header dword is decoded as follows: capability ID in bits 15:0, version in bits 19:16, following byte offset in bits 31:20.
- R3: A find returns in `found_off` the offset of the first header on the chain whose ID matches. It returns in `prev_off` the offset of the header visited before that one, or 0 when the match is the base header at 0x100.
- R4: When a find has no match, `found_off` is 0 and `prev_off` is the last header on the chain. When the base dword at 0x100 is all zeros, the chain is empty and both outputs are 0.
- R5: A search for ID 0 never matches, so its `prev_off` is the tail of the chain.
- R6: Every read address lies in the byte range 0x100 to 4088. Read data is taken one cycle after `mem_rd`. A read and a write never occur in the same cycle.
- R7: When a following offset is below 0x100, above 4088 or not a multiple of 4, the operation ends with `err` = 1 and performs no write.
- R8: An append at an offset other than 0x100 does two writes in order. It first writes the tail header with only bits 31:20 replaced by the new offset, and then writes the new header as {12'h000, version, ID}.
- R9: An append at 0x100 writes {old bits 31:20 at 0x100, version, ID} to the base dword and does no other write. It works on an empty chain too.
- R10: An append is rejected with `err` = 1 and no write when any of these holds: the offset is below 0x100, the offset is not a multiple of 4, `cap_size` is below 8, or offset + `cap_size` is 4096 or more.
- R11: An append at an offset other than 0x100 onto an empty chain ends with `err` = 1 and no write.
- R12: A walk that would read more than MAX_VISIT (default 1024) headers ends with `err` = 1, so a looping chain always terminates.
- R13: `done` lasts exactly one cycle. `busy` is high from the cycle after an accepted `start` until the cycle of `done`. A `start` while `busy` is high is ignored. After a successful append, `found_off` is the new offset and `prev_off` is the patched tail, or 0 for an append at 0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle operation request, taken while idle |
| mode | input | 1 | 0 = find, 1 = append |
| cap_id | input | 16 | ID searched for, or ID of the new capability |
| cap_ver | input | 4 | Version of the new capability |
| cap_off | input | 12 | Byte offset of the new capability |
| cap_size | input | 13 | Byte length of the new capability |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Error flag, valid with done |
| found_off | output | 12 | Match offset, or new offset for append |
| prev_off | output | 12 | Predecessor or tail offset |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 10 | Dword address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |

## Verification
The assertions check the following on every cycle: the read window, mutual exclusion of reads and writes, dword alignment of every following offset the engine writes, the shape of the done pulse, how busy follows start, and the bounds of every reported match offset. Other behaviours depend on the contents of the whole chain, and only the bench scenarios can show them. These include which header is the first match, the exact bits of a patched tail, preservation of the base pointer, the absence of writes after a rejected append, and termination of a self-looping chain. The bench checks them by comparing the full memory image against a shadow copy after every operation.

// File: rtl/ecap_walker.sv
module ecap_walker #(
  parameter int AW = 10,
  parameter int BASE = 256,
  parameter int MAX_VISIT = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [15:0]   cap_id,
  input  logic [3:0]    cap_ver,
  input  logic [AW+1:0] cap_off,
  input  logic [AW+2:0] cap_size,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW+1:0] found_off,
  output logic [AW+1:0] prev_off,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int OW = AW + 2;
  localparam int SPACE = 1 << OW;
  localparam int LIMIT = SPACE - 8;
  localparam int CW = $clog2(MAX_VISIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WT, S_PATCH, S_HDR, S_DONE} st_t;
  st_t st;

  logic          app_q;
  logic [15:0]   id_q;
  logic [3:0]    ver_q;
  logic [OW-1:0] off_q, cur, prv;
  logic [CW-1:0] cnt;
  logic [31:0]   hdr_q;
  logic          err_q;

  wire [OW-1:0] nxt = mem_rdata[31:20];
  wire [15:0]   walk_id = app_q ? 16'd0 : id_q;
  wire at_base  = int'(off_q) == BASE;
  wire bad_next = int'(nxt) < BASE || int'(nxt) > LIMIT || nxt[1:0] != 2'b00;
  wire bad_args = int'(cap_off) < BASE || cap_off[1:0] != 2'b00 || int'(cap_size) < 8 ||
                  int'(cap_off) + int'(cap_size) >= SPACE;

  assign busy = st != S_IDLE;
  assign done = st == S_DONE;
  assign err  = done & err_q;
  assign mem_rd = st == S_RD;
  assign mem_wr = st == S_PATCH || st == S_HDR;
  assign mem_addr = (st == S_HDR) ? off_q[OW-1:2] : cur[OW-1:2];
  assign mem_wdata = (st == S_PATCH) ? {off_q, hdr_q[19:0]}
                   : {at_base ? hdr_q[31:20] : 12'h000, ver_q, id_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      app_q <= 1'b0;
      id_q <= '0;
      ver_q <= '0;
      off_q <= '0;
      cur <= '0;
      prv <= '0;
      cnt <= '0;
      hdr_q <= '0;
      err_q <= 1'b0;
      found_off <= '0;
      prev_off <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          app_q <= mode;
          id_q <= cap_id;
          ver_q <= cap_ver;
          off_q <= cap_off;
          cur <= OW'(BASE);
          prv <= '0;
          cnt <= '0;
          hdr_q <= '0;
          err_q <= 1'b0;
          found_off <= '0;
          prev_off <= '0;
          if (mode && bad_args) begin
            err_q <= 1'b1;
            st <= S_DONE;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: st <= S_WT;
        S_WT: begin
          hdr_q <= mem_rdata;
          cnt <= cnt + 1'b1;
          if (int'(cur) == BASE && mem_rdata == 32'd0) begin
            if (app_q && !at_base) begin
              err_q <= 1'b1;
              st <= S_DONE;
            end else begin
              st <= app_q ? S_HDR : S_DONE;
            end
          end else if (app_q && at_base) begin
            st <= S_HDR;
          end else if (walk_id != 16'd0 && mem_rdata[15:0] == walk_id) begin
            found_off <= cur;
            prev_off <= prv;
            st <= S_DONE;
          end else if (nxt == '0) begin
            prev_off <= cur;
            st <= app_q ? S_PATCH : S_DONE;
          end else if (bad_next || int'(cnt) + 1 >= MAX_VISIT) begin
            err_q <= 1'b1;
            st <= S_DONE;
          end else begin
            prv <= cur;
            cur <= nxt;
            st <= S_RD;
          end
        end
        S_PATCH: st <= S_HDR;
        S_HDR: begin
          found_off <= off_q;
          if (at_base) prev_off <= '0;
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk #(
  parameter int AW = 10,
  parameter int BASE = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [AW+1:0] found_off,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata
);
  localparam int LIMIT = (1 << (AW + 2)) - 8;

  AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (int'(mem_addr) * 4 >= BASE && int'(mem_addr) * 4 <= LIMIT)); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R6
  AST_NEXT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata[21:20] == 2'b00); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R13
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R13
  AST_FOUND_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && found_off != '0) |-> (int'(found_off) >= BASE && found_off[1:0] == 2'b00)); // R3
endmodule

bind ecap_walker ecap_walker_chk #(.AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .found_off(found_off), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/tb_ecap_walker.sv
module tb_ecap_walker;
  localparam int MAXV = 1024;
  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic [15:0] cap_id = 0;
  logic [3:0] cap_ver = 0;
  logic [11:0] cap_off = 0;
  logic [12:0] cap_size = 0;
  logic busy, done, err, mem_rd, mem_wr;
  logic [11:0] found_off, prev_off;
  logic [9:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [1024];
  logic [31:0] shadow [1024];
  int n_chk = 0, n_fail = 0;
  logic r_err;
  logic [11:0] r_found, r_prev;

  always #10 clk = ~clk;

  ecap_walker dut (.*);

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) begin mem[i] = 0; shadow[i] = 0; end
  endtask

  task automatic put(input int off, input logic [31:0] v);
    mem[off >> 2] = v; shadow[off >> 2] = v;
  endtask

  function automatic void ref_walk(input logic [15:0] id, output logic [11:0] f,
                                   output logic [11:0] p, output logic e, output logic empty);
    int cur = 256, prv = 0, cnt = 0;
    logic [31:0] h;
    f = 0; p = 0; e = 0; empty = (shadow[64] == 0);
    if (empty) return;
    for (int k = 0; k < 4000; k++) begin
      h = shadow[cur >> 2];
      cnt++;
      if (id != 0 && h[15:0] == id) begin f = 12'(cur); p = 12'(prv); return; end
      if (h[31:20] == 0) begin p = 12'(cur); return; end
      if (h[31:20] < 256 || h[31:20] > 4088 || h[21:20] != 0 || cnt >= MAXV) begin e = 1; return; end
      prv = cur; cur = int'(h[31:20]);
    end
  endfunction

  function automatic void ref_append(input logic [15:0] id, input logic [3:0] ver, input int off,
                                     input int size, output logic [11:0] f, output logic [11:0] p,
                                     output logic e);
    logic empty;
    f = 0; p = 0; e = 0;
    if (off < 256 || off % 4 != 0 || size < 8 || off + size >= 4096) begin e = 1; return; end
    if (off == 256) begin
      shadow[64] = {shadow[64][31:20], ver, id}; f = 12'(off); return;
    end
    ref_walk(16'd0, f, p, e, empty);
    f = 0;
    if (e || empty) begin e = 1; p = 0; return; end
    shadow[p >> 2][31:20] = 12'(off);
    shadow[off >> 2] = {12'h000, ver, id};
    f = 12'(off);
  endfunction

  task automatic run(input logic m, input logic [15:0] id, input logic [3:0] ver,
                     input int off, input int size);
    int t = 0;
    @(negedge clk);
    mode = m; cap_id = id; cap_ver = ver; cap_off = 12'(off); cap_size = 13'(size); start = 1;
    @(negedge clk);
    start = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    r_err = err; r_found = found_off; r_prev = prev_off;
    if (t >= 5000) chk(0, "R13", "operation timed out");
    @(negedge clk);
    chk(!done, "R13", $sformatf("done held two cycles act=%0b exp=0", done));
  endtask

  function automatic bit mem_ok();
    for (int i = 0; i < 1024; i++) if (mem[i] !== shadow[i]) return 0;
    return 1;
  endfunction

  task automatic do_find(input logic [15:0] id, input string req);
    logic [11:0] f, p; logic e, em;
    ref_walk(id, f, p, e, em);
    run(0, id, 0, 0, 0);
    chk(r_err == e && (e || (r_found == f && r_prev == p)), req,
        $sformatf("find id=%0h act f=%h p=%h e=%0b exp f=%h p=%h e=%0b", id, r_found, r_prev, r_err, f, p, e));
    chk(mem_ok(), req, "find modified memory act=changed exp=unchanged");
  endtask

  task automatic do_app(input logic [15:0] id, input logic [3:0] ver, input int off, input int size,
                        input string req);
    logic [11:0] f, p; logic e;
    ref_append(id, ver, off, size, f, p, e);
    run(1, id, ver, off, size);
    chk(r_err == e && (e || (r_found == f && r_prev == p)), req,
        $sformatf("append off=%h act f=%h p=%h e=%0b exp f=%h p=%h e=%0b", off, r_found, r_prev, r_err, f, p, e));
    chk(mem_ok(), req, $sformatf("append off=%h memory image act=mismatch exp=match", off));
  endtask

  task automatic build_list(input int n, input int r);
    int offs[8];
    clear_mem();
    for (int i = 0; i < n; i++) offs[i] = 256 + 64 * ((i * 5 + r) % 56);
    for (int i = 0; i < n; i++)
      put(offs[i], {(i == n - 1) ? 12'h000 : 12'(offs[i + 1]), 4'($urandom_range(0, 15)),
                    16'($urandom_range(1, 6))});
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_mem();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R1",
        $sformatf("reset act=%0b%0b%0b%0b exp=0000", busy, done, mem_rd, mem_wr));
    rst_n = 1;

    do_find(16'h0003, "R4");
    do_app(16'h0011, 4'h2, 512, 16, "R11");

    clear_mem();
    put(256, {12'h140, 4'h1, 16'h0007});
    put(320, {12'h200, 4'h2, 16'h0009});
    put(512, {12'h000, 4'h3, 16'h0007});
    do_find(16'h0007, "R3");
    do_find(16'h0009, "R2");
    do_find(16'h0005, "R4");
    do_find(16'h0000, "R5");
    do_app(16'h00AA, 4'h5, 256, 8, "R9");
    do_app(16'h00BB, 4'h6, 1024, 32, "R8");
    do_app(16'h00CC, 4'h1, 200, 16, "R10");
    do_app(16'h00CC, 4'h1, 1026, 16, "R10");
    do_app(16'h00CC, 4'h1, 2048, 4, "R10");
    do_app(16'h00CC, 4'h1, 4080, 16, "R10");

    clear_mem();
    do_app(16'h0042, 4'h4, 256, 8, "R9");

    clear_mem();
    put(256, {12'h080, 4'h0, 16'h0001});
    do_find(16'h0002, "R7");
    put(256, {12'h142, 4'h0, 16'h0001});
    do_app(16'h0002, 4'h0, 1024, 8, "R7");
    put(256, {12'hFFC, 4'h0, 16'h0001});
    do_find(16'h0002, "R7");

    clear_mem();
    put(256, {12'h140, 4'h0, 16'h0001});
    put(320, {12'h140, 4'h0, 16'h0002});
    do_find(16'h0009, "R12");

    clear_mem();
    put(256, {12'h000, 4'h0, 16'h0001});
    @(negedge clk);
    mode = 0; cap_id = 16'h0001; start = 1;
    @(negedge clk);
    mode = 1; cap_id = 16'h00EE; cap_off = 12'h400; cap_size = 13'd8;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk(!err && found_off == 12'h100 && prev_off == 12'h000, "R13",
        $sformatf("start while busy act f=%h p=%h exp f=100 p=000", found_off, prev_off));
    @(negedge clk);
    chk(mem_ok(), "R13", "start while busy act=memory written exp=unchanged");

    for (int it = 0; it < 40; it++) begin
      build_list($urandom_range(1, 8), $urandom_range(0, 55));
      do_find(16'($urandom_range(0, 7)), "R3");
      do_app(16'($urandom_range(1, 255)), 4'($urandom_range(0, 15)),
             1024 + 4 * $urandom_range(0, 700), $urandom_range(8, 64), "R8");
      do_find(16'($urandom_range(0, 7)), "R4");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule